// File: doc/BRIEF.md
# GPIO bank with wake-event logic

This block is a bank of general-purpose I/O bits controlled by a host through a small register read/write port. Each bit has three control settings: a direction (input or output), a polarity (inverted or not) and a data bit. An output bit drives its data bit onto its pin. When the polarity is set, the bit is inverted on the way out. An input bit samples its pin through a two-flop synchronizer. A host read of an input bit returns that sample, inverted when the polarity is set. What a host read or write does to a data bit therefore depends on the bit's direction.

Each input bit also feeds an edge detector. The polarity bit chooses the edge that the detector looks for. A detected edge sets a sticky wake status bit. The host clears a status bit by writing 1 to it. The status bits are masked by a per-bit enable and by a global enable, and the result is ORed into one registered wake event output. A bit configured as output takes no part in the wake logic.

The register index on `addr` is 0 for direction (1 = output), 1 for polarity (1 = inverted), 2 for data, 3 for wake status, 4 for per-bit wake enable and 5 for global enable (bit 0). Bit i of every register belongs to pin i. Reads are registered: `rdata` shows the addressed value in the cycle after the one in which `rd_en` is high.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset every bit is an input with polarity clear. The data, status, per-bit enable and global enable registers all read 0, `pin_oe` is 0 and `wake_evt` is 0.
- R2: For an input bit, a read of register 2 returns the synchronized pin level, XORed with the bit's polarity.
- R3: A write to register 2 leaves the data bit of every input bit unchanged. This is visible once the bit is turned into an output.
- R4: `pin_oe` bit i equals direction bit i, and `pin_out` bit i equals data bit i XOR polarity bit i.
- R5: For an output bit, a read of register 2 returns the last written data bit, not the pin level and not the inverted value.
- R6: With polarity clear, a low-to-high edge on an input pin sets its status bit, and a high-to-low edge does not.
- R7: With polarity set, a high-to-low edge on an input pin sets its status bit, and a low-to-high edge does not.
- R8: A pin edge on a bit configured as output never sets its status bit.
- R9: Status bits are sticky. Writing 1 to a bit of register 3 clears it, and writing 0 leaves it unchanged.
- R10: If a detected edge and a host clear hit the same status bit in the same cycle, the bit stays set.
- R11: `wake_evt` is 1 in the cycle after one in which the global enable is set and some bit has both its status and its per-bit enable set. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 3 | Register index |
| wdata | input | NBITS | Host write data |
| rdata | output | NBITS | Registered host read data |
| pin_in | input | NBITS | Pin levels from the pads |
| pin_out | output | NBITS | Pin drive values |
| pin_oe | output | NBITS | Pin output enables |
| wake_evt | output | 1 | Registered wake event |

## Verification
The data path is tried in three settings: all inputs with polarity clear, all inputs with polarity set, and a mixed direction pattern in which the output pins carry levels that differ from their data bits. This separates reading the pin from reading the register, and inverted reads from plain ones. The wake logic gets rising and falling edges under both polarities, edges on output bits, and enable patterns where the status and enable bits do not overlap. It also gets a host clear timed to land in the same cycle as a fresh edge, with a second cleared bit beside it, so that the clear-against-set priority is checked bit by bit.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_POL  = 3'd1,
    REG_DATA = 3'd2,
    REG_STAT = 3'd3,
    REG_WEN  = 3'd4,
    REG_GEN  = 3'd5
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_wake_status.sv
module gpio_wake_status #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] smp,
  input  logic [NBITS-1:0] dir,
  input  logic [NBITS-1:0] pol,
  input  logic [NBITS-1:0] clr,
  output logic [NBITS-1:0] status
);
  logic [NBITS-1:0] prev_q;
  logic [NBITS-1:0] hit;
  logic [NBITS-1:0] status_q;
  logic [NBITS-1:0] status_d;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic rise;
    logic fall;
    assign rise   = smp[i] & ~prev_q[i];
    assign fall   = ~smp[i] & prev_q[i];
    assign hit[i] = ~dir[i] & (pol[i] ? fall : rise);
  end

  // a new edge wins over a clear
  always_comb begin
    status_d = (status_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= smp;
      status_q <= status_d;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_host_regs.sv
module gpio_host_regs
  import gpio_wake_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBITS-1:0]  wdata,
  input  logic [NBITS-1:0]  smp,
  input  logic [NBITS-1:0]  status,
  output logic [NBITS-1:0]  rdata,
  output logic [NBITS-1:0]  dir,
  output logic [NBITS-1:0]  pol,
  output logic [NBITS-1:0]  data,
  output logic [NBITS-1:0]  wen,
  output logic              gen,
  output logic [NBITS-1:0]  stat_clr
);
  logic [NBITS-1:0] dir_q, pol_q, data_q, wen_q, rdata_q;
  logic [NBITS-1:0] dir_d, pol_d, data_d, wen_d, rd_sel;
  logic             gen_q, gen_d;

  always_comb begin
    dir_d    = dir_q;
    pol_d    = pol_q;
    data_d   = data_q;
    wen_d    = wen_q;
    gen_d    = gen_q;
    stat_clr = '0;
    if (wr_en) begin
      case (gpio_reg_e'(addr))
        REG_DIR:  dir_d    = wdata;
        REG_POL:  pol_d    = wdata;
        REG_DATA: data_d   = (data_q & ~dir_q) | (wdata & dir_q);
        REG_STAT: stat_clr = wdata;
        REG_WEN:  wen_d    = wdata;
        REG_GEN:  gen_d    = wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (gpio_reg_e'(addr))
      REG_DIR:  rd_sel = dir_q;
      REG_POL:  rd_sel = pol_q;
      REG_DATA: rd_sel = (data_q & dir_q) | ((smp ^ pol_q) & ~dir_q);
      REG_STAT: rd_sel = status;
      REG_WEN:  rd_sel = wen_q;
      REG_GEN:  rd_sel = {{(NBITS-1){1'b0}}, gen_q};
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      pol_q   <= '0;
      data_q  <= '0;
      wen_q   <= '0;
      gen_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      dir_q  <= dir_d;
      pol_q  <= pol_d;
      data_q <= data_d;
      wen_q  <= wen_d;
      gen_q  <= gen_d;
      if (rd_en) begin
        rdata_q <= rd_sel;
      end
    end
  end

  assign rdata = rdata_q;
  assign dir   = dir_q;
  assign pol   = pol_q;
  assign data  = data_q;
  assign wen   = wen_q;
  assign gen   = gen_q;
endmodule

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank
  import gpio_wake_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBITS-1:0]  wdata,
  output logic [NBITS-1:0]  rdata,
  input  logic [NBITS-1:0]  pin_in,
  output logic [NBITS-1:0]  pin_out,
  output logic [NBITS-1:0]  pin_oe,
  output logic              wake_evt
);
  logic             rst_meta_q, rst_core_n;
  logic [NBITS-1:0] smp, dir_q, pol_q, data_q, wen_q, status_q, stat_clr;
  logic             gen_q;
  logic             wake_d, wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  gpio_sync #(.W(NBITS)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(pin_in), .q(smp)
  );

  gpio_host_regs #(.NBITS(NBITS)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .smp(smp), .status(status_q),
    .rdata(rdata), .dir(dir_q), .pol(pol_q), .data(data_q),
    .wen(wen_q), .gen(gen_q), .stat_clr(stat_clr)
  );

  gpio_wake_status #(.NBITS(NBITS)) u_wake (
    .clk(clk), .rst_n(rst_core_n), .smp(smp), .dir(dir_q),
    .pol(pol_q), .clr(stat_clr), .status(status_q)
  );

  always_comb begin
    wake_d = gen_q & (|(status_q & wen_q));
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
    end
  end

  assign pin_out  = data_q ^ pol_q;
  assign pin_oe   = dir_q;
  assign wake_evt = wake_q;
endmodule

// File: rtl/gpio_wake_bank_chk.sv
module gpio_wake_bank_chk
  import gpio_wake_pkg::*;
#(
  parameter int NBITS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NBITS-1:0]  wdata,
  input logic [NBITS-1:0]  dir,
  input logic [NBITS-1:0]  data,
  input logic [NBITS-1:0]  status,
  input logic [NBITS-1:0]  wen,
  input logic              gen,
  input logic              wake_evt
);
  logic [NBITS-1:0] host_clr;
  assign host_clr = (wr_en && addr == REG_STAT) ? wdata : '0;

  // R3: input bits keep their data bit across any write
  assert_input_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((data ^ $past(data)) & ~$past(dir)) == '0));

  // R8: status bits only rise on bits that were inputs
  assert_output_no_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(dir)) == '0));

  // R9: a status bit only falls when the host cleared it
  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~status & ~$past(host_clr)) == '0));

  // R11: registered wake event
  assert_wake_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wake_evt == ($past(gen) && (|($past(status) & $past(wen))))));

  // R11: no wake while globally disabled
  assert_wake_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |=> !wake_evt);
endmodule

bind gpio_wake_bank gpio_wake_bank_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .dir(dir_q), .data(data_q), .status(status_q), .wen(wen_q), .gen(gen_q),
  .wake_evt(wake_evt)
);

// File: tb/gpio_wake_bank_bench.sv
module gpio_wake_bank_bench;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [2:0]    addr;
  logic [NB-1:0] wdata, rdata, pin_in, pin_out, pin_oe;
  logic          wake_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NB-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 1'b0;

  always #4 clk = ~clk;

  gpio_wake_bank #(.NBITS(NB)) u_gpio_wake_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .wake_evt(wake_evt)
  );

  task automatic chk(input logic [NB-1:0] act, input logic [NB-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each read result against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [NB-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata, e, t);
    end
  end

  task automatic host_wr(input logic [2:0] a, input logic [NB-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, input logic [NB-1:0] e, input string tag);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk(pin_oe, 8'h00, "R1 pin_oe");
    chk({7'd0, wake_evt}, 8'h00, "R1 wake_evt");
    for (int a = 0; a < 6; a++) host_rd(a[2:0], 8'h00, "R1 register reset");

    // R2 / R6 / R9 with polarity clear
    pin_in = 8'hA5; settle();
    host_rd(3'd2, 8'hA5, "R2 input read");
    host_rd(3'd3, 8'hA5, "R6 rising edge sets status");
    host_wr(3'd3, 8'h05);
    host_rd(3'd3, 8'hA0, "R9 partial clear");
    host_wr(3'd3, 8'h00);
    host_rd(3'd3, 8'hA0, "R9 write 0 keeps status");
    host_wr(3'd3, 8'hA0);
    pin_in = 8'h00; settle();
    host_rd(3'd3, 8'h00, "R6 falling edge ignored");

    // R2 / R7 with polarity set
    host_wr(3'd1, 8'hFF);
    host_rd(3'd2, 8'hFF, "R2 inverted input read");
    pin_in = 8'h0F; settle();
    host_rd(3'd3, 8'h00, "R7 rising edge ignored");
    pin_in = 8'h00; settle();
    host_rd(3'd3, 8'h0F, "R7 falling edge sets status");
    host_wr(3'd3, 8'hFF);
    host_wr(3'd1, 8'h00);

    // R3 / R4 / R5 / R8 mixed directions
    host_wr(3'd2, 8'hFF);
    host_wr(3'd0, 8'hF0);
    host_rd(3'd2, 8'h00, "R3 write to inputs ignored");
    chk(pin_oe, 8'hF0, "R4 output enable");
    chk(pin_out, 8'h00, "R3 no data reached outputs");
    host_wr(3'd2, 8'hAA);
    pin_in = 8'h5F; settle();
    host_rd(3'd2, 8'hAF, "R5 output read returns data");
    chk(pin_out, 8'hA0, "R4 drive data");
    host_wr(3'd1, 8'h30);
    chk(pin_out, 8'h90, "R4 drive inverted");
    host_rd(3'd2, 8'hAF, "R5 output read not inverted");
    host_wr(3'd1, 8'h00);
    host_rd(3'd3, 8'h0F, "R8 output pins set no status");
    pin_in = 8'h00; settle();
    host_wr(3'd3, 8'hFF);
    host_wr(3'd0, 8'h00);

    // R11 wake gating
    pin_in = 8'h01; settle();
    chk({7'd0, wake_evt}, 8'h00, "R11 no enables");
    host_wr(3'd4, 8'h02);
    host_wr(3'd5, 8'h01);
    @(negedge clk); @(negedge clk);
    chk({7'd0, wake_evt}, 8'h00, "R11 enable mismatch");
    host_wr(3'd4, 8'h01);
    chk({7'd0, wake_evt}, 8'h00, "R11 registered delay");
    @(negedge clk);
    chk({7'd0, wake_evt}, 8'h01, "R11 wake asserted");
    host_wr(3'd5, 8'h00);
    @(negedge clk);
    chk({7'd0, wake_evt}, 8'h00, "R11 global disable");

    // R10 clear colliding with a new edge
    pin_in = 8'h00; settle();
    pin_in = 8'h02; settle();
    pin_in = 8'h00; settle();
    host_rd(3'd3, 8'h03, "R9 status sticky");
    pin_in = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    host_wr(3'd3, 8'h03);
    host_rd(3'd3, 8'h01, "R10 edge beats clear");

    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule